// File: doc/BRIEF.md
# I2C Target Controller with Clock Stretching

This block is the bus-side half of an I2C target (slave) for an 8-bit host processor. It watches the SCL and SDA pads through a synchronizer and finds START and STOP conditions. It shifts in a 7-bit address plus direction bit and compares the address with a host-programmable register. The block never drives a pad high. It only raises a pull-low enable for each line, and the open-drain pad and the bus pull-up do the rest.

When the controller writes to the target, each received byte lands in a single holding buffer for the host to read. When the controller reads, the target pulls SCL low after every acknowledged byte. SCL stays low until the host has put the next byte in the buffer and set a release bit. The bits then go out MSB first, with SDA changing only while SCL is low. After every byte the host sees an interrupt flag. It clears that flag itself.

Top module: `i2c_target_stretch`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the block to idle from any state. In the next clock both pull enables are low, and status bit 1 (read pending) is cleared.
- R2: After a START, the block pulls SDA low during the ninth SCL pulse only if the seven address bits, sent MSB first, equal the own-address register (select 2, bits 6:0). On a match it loads the full address byte into the buffer (select 0). On a mismatch it ignores the rest of the transfer.
- R3: When the address matches with direction bit (bit 0) equal to 1, status bit 1 becomes 1 and the buffer holds the address byte. After the ninth SCL fall the block keeps SCL pulled low.
- R4: A write of 1 to status bit 3 (release) takes effect only after a host write to the buffer since the last address match or the last release. Otherwise the bit stays 0 and SCL stays held.
- R5: When the release is taken, the buffer byte is sent MSB first. SDA changes only in cycles that follow an SCL fall, so each bit is stable while SCL is high.
- R6: Status bit 4 and `irq_o` become 1 after the ninth SCL fall of every acknowledged-address or data byte. They drop only when the host writes status with bit 4 equal to 0.
- R7: If the controller leaves SDA high in the ninth pulse after a transmitted byte, the block releases both lines and waits for a new START.
- R8: If the controller pulls SDA low in the ninth pulse after a transmitted byte, the block holds SCL low again until the next release.
- R9: In receive mode a completed byte is stored in the buffer and status bit 0 (full) is set. The byte is acknowledged. A host read of select 0 clears bit 0.
- R10: If a received byte completes while status bit 0 is still 1, status bit 2 (overflow) is set, no acknowledge is given and the buffer is unchanged. A status write with bit 2 equal to 0 clears it.
- R11: In transmit mode status bit 0 is set by the host buffer write and stays 1 until the eighth data bit has been clocked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_pull_o | output | 1 | Pull SCL pad low when 1 |
| sda_pull_o | output | 1 | Pull SDA pad low when 1 |
| reg_sel | input | 2 | Register select: 0 buffer, 1 status, 2 own address |
| reg_we | input | 1 | Host write strobe |
| reg_re | input | 1 | Host read strobe (side effect on select 0) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Selected register value |
| irq_o | output | 1 | Per-byte interrupt flag |

## Verification
Write transfers are run with data bytes 0x00, 0xFF, 0xA5 and 0x81. These show whether bits are stuck, swapped or shifted by one position. Addresses are tried that differ from the own address in only the lowest bit and in only the highest bit, which shows whether the full seven bits are compared. Read transfers are run with both an acknowledge and a not-acknowledge from the controller, and a write is run with the buffer left unread. Together these separate re-stretching, return to idle and the overflow path.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX,
      ST_RX_ACK,
      ST_HOLD,
      ST_TX,
      ST_TX_ACK
   } tgt_state_e;

   typedef struct packed {
      logic addr_load;
      logic rw_set;
      logic rx_load;
      logic ovf;
      logic irq;
      logic tx_done;
      logic rel_take;
      logic stop;
   } tgt_ev_t;

   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_STAT = 2'd1;
   localparam logic [1:0] SEL_OWN  = 2'd2;

   localparam int unsigned SB_FULL = 0;
   localparam int unsigned SB_RW   = 1;
   localparam int unsigned SB_OVF  = 2;
   localparam int unsigned SB_REL  = 3;
   localparam int unsigned SB_IRQ  = 4;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_d  <= scl_ff[STAGES-1];
         sda_d  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [DATA_W-2:0] own_addr,
   input  logic              buf_full,
   input  logic [DATA_W-1:0] buf_byte,
   input  logic              rel_req,
   output logic              scl_pull,
   output logic              sda_pull,
   output tgt_ev_t           ev,
   output logic [DATA_W-1:0] ev_byte
);

   localparam int unsigned CW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] LAST = CW'(DATA_W);

   tgt_state_e        state;
   logic [CW-1:0]     bitcnt;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] tx_sr;
   logic              rd_mode;
   logic              m_nack;

   logic live;
   logic byte_end;
   logic addr_hit;

   assign live     = !start_det && !stop_det;
   assign byte_end = scl_fall && (bitcnt == LAST);
   assign addr_hit = (rx_sr[DATA_W-1:1] == own_addr);
   assign ev_byte  = rx_sr;

   always_comb begin
      ev           = '0;
      ev.addr_load = live && (state == ST_ADDR) && byte_end && addr_hit;
      ev.rw_set    = ev.addr_load && rx_sr[0];
      ev.rx_load   = live && (state == ST_RX) && byte_end && !buf_full;
      ev.ovf       = live && (state == ST_RX) && byte_end && buf_full;
      ev.irq       = live && scl_fall &&
                     ((state == ST_ADDR_ACK) || (state == ST_RX_ACK) || (state == ST_TX_ACK));
      ev.tx_done   = live && (state == ST_TX) && byte_end;
      ev.rel_take  = live && (state == ST_HOLD) && rel_req;
      ev.stop      = stop_det;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         rd_mode  <= 1'b0;
         m_nack   <= 1'b1;
         scl_pull <= 1'b0;
         sda_pull <= 1'b0;
      end else if (start_det) begin
         state    <= ST_ADDR;
         bitcnt   <= '0;
         scl_pull <= 1'b0;
         sda_pull <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         scl_pull <= 1'b0;
         sda_pull <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               scl_pull <= 1'b0;
               sda_pull <= 1'b0;
            end
            ST_ADDR: begin
               if (scl_rise && bitcnt != LAST) begin
                  rx_sr  <= {rx_sr[DATA_W-2:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_end) begin
                  if (addr_hit) begin
                     sda_pull <= 1'b1;
                     rd_mode  <= rx_sr[0];
                     state    <= ST_ADDR_ACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  sda_pull <= 1'b0;
                  bitcnt   <= '0;
                  if (rd_mode) begin
                     scl_pull <= 1'b1;
                     state    <= ST_HOLD;
                  end else begin
                     state <= ST_RX;
                  end
               end
            end
            ST_RX: begin
               if (scl_rise && bitcnt != LAST) begin
                  rx_sr  <= {rx_sr[DATA_W-2:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_end) begin
                  sda_pull <= !buf_full;
                  state    <= ST_RX_ACK;
               end
            end
            ST_RX_ACK: begin
               if (scl_fall) begin
                  sda_pull <= 1'b0;
                  bitcnt   <= '0;
                  state    <= ST_RX;
               end
            end
            ST_HOLD: begin
               if (rel_req) begin
                  scl_pull <= 1'b0;
                  tx_sr    <= buf_byte;
                  sda_pull <= ~buf_byte[DATA_W-1];
                  bitcnt   <= '0;
                  state    <= ST_TX;
               end
            end
            ST_TX: begin
               if (scl_rise && bitcnt != LAST) begin
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_end) begin
                  sda_pull <= 1'b0;
                  m_nack   <= 1'b1;
                  state    <= ST_TX_ACK;
               end else if (scl_fall) begin
                  tx_sr    <= {tx_sr[DATA_W-2:0], 1'b0};
                  sda_pull <= ~tx_sr[DATA_W-2];
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  m_nack <= sda_s;
               end else if (scl_fall) begin
                  bitcnt <= '0;
                  if (m_nack) begin
                     state <= ST_IDLE;
                  end else begin
                     scl_pull <= 1'b1;
                     state    <= ST_HOLD;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R5: while the synchronized SCL stays high during a data bit, SDA drive is frozen
   assert_sda_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX && scl_s && $past(scl_s)) |-> $stable(sda_pull));

   // R2: a completed address byte that does not match never produces an acknowledge
   assert_no_ack_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR && byte_end && !addr_hit && live) |=> !sda_pull);

   // R8: acknowledged transmit byte leads to SCL held low
   assert_restretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX_ACK && scl_fall && !m_nack && live) |=> scl_pull);

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
   import i2c_tgt_pkg::*;
#(
   parameter int unsigned            DATA_W     = 8,
   parameter logic [DATA_W-2:0]      RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_sel,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  tgt_ev_t           ev,
   input  logic [DATA_W-1:0] ev_byte,
   output logic [DATA_W-1:0] buf_q,
   output logic              full_q,
   output logic              rel_q,
   output logic [DATA_W-2:0] own_q,
   output logic              irq_q
);

   localparam int unsigned PAD_W = DATA_W - 5;

   logic rw_q;
   logic ovf_q;
   logic armed_q;

   logic data_wr;
   logic data_rd;
   logic stat_wr;
   logic own_wr;

   assign data_wr = reg_we && (reg_sel == SEL_DATA);
   assign data_rd = reg_re && (reg_sel == SEL_DATA);
   assign stat_wr = reg_we && (reg_sel == SEL_STAT);
   assign own_wr  = reg_we && (reg_sel == SEL_OWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q   <= '0;
         full_q  <= 1'b0;
         rw_q    <= 1'b0;
         ovf_q   <= 1'b0;
         rel_q   <= 1'b0;
         irq_q   <= 1'b0;
         armed_q <= 1'b0;
         own_q   <= RESET_ADDR;
      end else begin
         if (data_wr) begin
            buf_q   <= reg_wdata;
            full_q  <= 1'b1;
            armed_q <= 1'b1;
         end else if (data_rd) begin
            full_q <= 1'b0;
         end
         if (stat_wr) begin
            if (reg_wdata[SB_REL] && armed_q) rel_q <= 1'b1;
            if (!reg_wdata[SB_OVF]) ovf_q <= 1'b0;
            if (!reg_wdata[SB_IRQ]) irq_q <= 1'b0;
         end
         if (own_wr) own_q <= reg_wdata[DATA_W-2:0];
         if (ev.addr_load || ev.rx_load) begin
            buf_q  <= ev_byte;
            full_q <= 1'b1;
         end
         if (ev.addr_load) armed_q <= 1'b0;
         if (ev.tx_done)   full_q  <= 1'b0;
         if (ev.ovf)       ovf_q   <= 1'b1;
         if (ev.irq)       irq_q   <= 1'b1;
         if (ev.rw_set)    rw_q    <= 1'b1;
         if (ev.stop)      rw_q    <= 1'b0;
         if (ev.rel_take) begin
            rel_q   <= 1'b0;
            armed_q <= 1'b0;
         end
      end
   end

   always_comb begin
      unique case (reg_sel)
         SEL_DATA: reg_rdata = buf_q;
         SEL_STAT: reg_rdata = {{PAD_W{1'b0}}, irq_q, rel_q, ovf_q, rw_q, full_q};
         SEL_OWN:  reg_rdata = {1'b0, own_q};
         default:  reg_rdata = '0;
      endcase
   end

   // R6: the interrupt flag only falls through a host status write with bit 4 low
   assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !(stat_wr && !reg_wdata[SB_IRQ])) |=> irq_q);

   // R10: an overflowing byte leaves the buffer untouched
   assert_ovf_keeps_buf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.ovf && !data_wr) |=> $stable(buf_q));

   // R4: release can only appear when a buffer write armed it
   assert_release_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rel_q) |-> $past(armed_q));

   // R9: a host read of the buffer empties it when nothing refills it
   assert_read_clears_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !data_wr && !ev.rx_load && !ev.addr_load) |=> !full_q);

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
   import i2c_tgt_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [DATA_W-2:0] RESET_ADDR  = 7'h42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   input  logic [1:0]        reg_sel,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);

   if (DATA_W != 8) begin : g_bad_width
      $error("i2c_target_stretch: bus bytes are 8 bits wide");
   end

   logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [DATA_W-1:0] buf_q;
   logic              full_q;
   logic              rel_q;
   logic [DATA_W-2:0] own_q;
   tgt_ev_t           ev;
   logic [DATA_W-1:0] ev_byte;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_tgt_engine #(.DATA_W(DATA_W)) i_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .own_addr  (own_q),
      .buf_full  (full_q),
      .buf_byte  (buf_q),
      .rel_req   (rel_q),
      .scl_pull  (scl_pull_o),
      .sda_pull  (sda_pull_o),
      .ev        (ev),
      .ev_byte   (ev_byte)
   );

   i2c_tgt_regs #(.DATA_W(DATA_W), .RESET_ADDR(RESET_ADDR)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ev        (ev),
      .ev_byte   (ev_byte),
      .buf_q     (buf_q),
      .full_q    (full_q),
      .rel_q     (rel_q),
      .own_q     (own_q),
      .irq_q     (irq_o)
   );

   // R1: a STOP seen on the synchronized lines frees both pads on the next clock
   assert_stop_frees_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!scl_pull_o && !sda_pull_o));

endmodule

// File: tb/test_i2c_target_stretch.sv
module test_i2c_target_stretch;

   localparam int H = 10;
   localparam int NV = 6;
   // [15:9] address, [8:1] data byte, [0] address expected to match
   localparam logic [15:0] VEC [NV] = '{
      {7'h42, 8'hA5, 1'b1},
      {7'h42, 8'h00, 1'b1},
      {7'h43, 8'h5A, 1'b0},
      {7'h42, 8'hFF, 1'b1},
      {7'h02, 8'h3C, 1'b0},
      {7'h42, 8'h81, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       scl_pull_o, sda_pull_o, irq_o;
   logic [1:0] reg_sel = 2'd0;
   logic       reg_we = 1'b0;
   logic       reg_re = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       scl_line, sda_line;
   int         checks = 0;
   int         errors = 0;
   int         unstable = 0;

   assign scl_line = m_scl & ~scl_pull_o;
   assign sda_line = m_sda & ~sda_pull_o;

   always #5ns clk = ~clk;

   i2c_target_stretch i_i2c_target_stretch (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_line),
      .sda_i      (sda_line),
      .scl_pull_o (scl_pull_o),
      .sda_pull_o (sda_pull_o),
      .reg_sel    (reg_sel),
      .reg_we     (reg_we),
      .reg_re     (reg_re),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .irq_o      (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic host_rd(input logic [1:0] sel, output logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; reg_re = (sel == 2'd0);
      #1ns d = reg_rdata;
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; wait_clk(H);
      m_scl = 1'b1; wait_clk(H);
      m_sda = 1'b0; wait_clk(H);
      m_scl = 1'b0; wait_clk(H);
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; wait_clk(H);
      m_scl = 1'b1;
      while (!scl_line) @(negedge clk);
      wait_clk(H);
      m_sda = 1'b1; wait_clk(2 * H);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; wait_clk(H);
      m_scl = 1'b1;
      while (!scl_line) @(negedge clk);
      wait_clk(H);
      m_scl = 1'b0; wait_clk(H);
   endtask

   task automatic recv_bit(output logic b);
      logic first;
      m_sda = 1'b1; wait_clk(H);
      m_scl = 1'b1;
      while (!scl_line) @(negedge clk);
      wait_clk(2);
      first = sda_line;
      wait_clk(H - 4);
      b = sda_line;
      if (first !== b) unstable++;
      wait_clk(2);
      m_scl = 1'b0; wait_clk(H);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic nack);
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(nack);
   endtask

   task automatic recv_byte(input logic give_nack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) recv_bit(d[i]);
      send_bit(give_nack);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      logic       ak;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);

      // reset state
      chk("R1 reset scl pull", scl_pull_o, 0);
      chk("R1 reset sda pull", sda_pull_o, 0);
      host_rd(2'd1, rd); chk("R1 reset status", rd, 8'h00);
      host_rd(2'd2, rd); chk("R2 reset own address", rd, 8'h42);

      // table-driven write transfers
      for (int v = 0; v < NV; v++) begin
         logic [6:0] a;
         logic [7:0] d;
         logic       hit;
         a = VEC[v][15:9]; d = VEC[v][8:1]; hit = VEC[v][0];
         host_wr(2'd1, 8'h00);
         i2c_start();
         send_byte({a, 1'b0}, ak);
         chk("R2 address acknowledge", ak, !hit);
         if (hit) begin
            chk("R6 irq after address", irq_o, 1);
            host_rd(2'd0, rd); chk("R2 address byte in buffer", rd, {a, 1'b0});
            host_wr(2'd1, 8'h00);
            send_byte(d, ak);
            chk("R9 data acknowledged", ak, 0);
            host_rd(2'd1, rd); chk("R9 full set", rd[0], 1);
            host_rd(2'd0, rd); chk("R9 data byte", rd, d);
            host_rd(2'd1, rd); chk("R9 full cleared by read", rd[0], 0);
         end else begin
            send_byte(d, ak);
            chk("R2 mismatch data ignored", ak, 1);
            host_rd(2'd1, rd); chk("R2 mismatch leaves status", rd, 8'h00);
         end
         i2c_stop();
         chk("R1 lines free after stop", {scl_pull_o, sda_pull_o}, 2'b00);
      end

      // read transfer with stretching
      i2c_start();
      send_byte({7'h42, 1'b1}, ak);
      chk("R2 read address ack", ak, 0);
      wait_clk(20);
      chk("R3 scl held after address", scl_pull_o, 1);
      host_rd(2'd1, rd);
      chk("R3 read pending bit", rd[1], 1);
      chk("R6 irq after read address", rd[4], 1);
      host_rd(2'd0, rd); chk("R3 address byte in buffer", rd, 8'h85);
      host_wr(2'd1, 8'h18);
      wait_clk(20);
      chk("R4 release refused without write", scl_pull_o, 1);
      host_rd(2'd1, rd); chk("R4 release bit stays 0", rd[3], 0);
      host_wr(2'd0, 8'hC3);
      host_rd(2'd1, rd); chk("R11 full after host write", rd[0], 1);
      host_wr(2'd1, 8'h18);
      recv_byte(1'b0, rd);
      chk("R5 first transmitted byte", rd, 8'hC3);
      chk("R5 sda stable during scl high", unstable, 0);
      wait_clk(20);
      chk("R8 scl held after master ack", scl_pull_o, 1);
      host_rd(2'd1, rd); chk("R11 full cleared after last bit", rd[0], 0);
      chk("R6 irq still set", irq_o, 1);
      host_wr(2'd1, 8'h00);
      chk("R6 irq cleared by host write", irq_o, 0);
      host_wr(2'd0, 8'h3C);
      host_wr(2'd1, 8'h08);
      recv_byte(1'b1, rd);
      chk("R5 second transmitted byte", rd, 8'h3C);
      chk("R5 sda stable second byte", unstable, 0);
      wait_clk(20);
      chk("R7 lines free after master nack", {scl_pull_o, sda_pull_o}, 2'b00);
      host_rd(2'd1, rd); chk("R7 irq after nack byte", rd[4], 1);
      i2c_stop();
      host_rd(2'd1, rd); chk("R1 stop clears read pending", rd[1], 0);

      // overflow: address byte left unread
      host_wr(2'd1, 8'h00);
      i2c_start();
      send_byte({7'h42, 1'b0}, ak);
      chk("R2 write address ack", ak, 0);
      send_byte(8'h77, ak);
      chk("R10 no ack on overflow", ak, 1);
      host_rd(2'd1, rd); chk("R10 overflow bit", rd[2], 1);
      host_wr(2'd1, 8'h10);
      host_rd(2'd1, rd); chk("R10 overflow cleared", rd[2], 0);
      host_rd(2'd0, rd); chk("R10 buffer unchanged", rd, 8'h84);
      i2c_stop();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule